// File: doc/BRIEF.md
# Single-Error-Correcting Page Chunk ECC

This block protects one fixed-size chunk of a flash page, 256 bytes by default, with a short parity code. Bytes stream in at most one per cycle. A start strobe opens a chunk, and the chunk closes when its last byte has been accepted. In encode mode the block produces the 22-bit code that is written to the spare area next to the chunk. In check mode it recomputes the code over the bytes read back and XORs it with the stored code to form a syndrome. From the syndrome it reports one of four outcomes. For a single flipped data bit it also gives the byte index and the bit index that the page-buffer logic must flip.

The code has two parts. The line parity has two bits for each byte-address bit: one is the parity of all bytes whose address has that bit clear, the other the parity of all bytes whose address has it set. The column parity has two bits for each of the three bit-position bits within a byte, formed the same way. A single flipped data bit therefore flips exactly one bit of every pair. The odd halves of the pairs then spell out its location. The parameter `CHUNK_BYTES` (a power of two) selects the chunk size, and the code width is twice the byte-address width plus six. A 512-byte chunk therefore gets a 24-bit code with the same single-bit correction.

The controller has three states: `ST_IDLE` (waiting for a start), `ST_FILL` (accepting bytes) and `ST_REPORT` (a single cycle that presents the result). Transitions: a start strobe moves any state to `ST_FILL` and clears the accumulators. `ST_FILL` moves to `ST_REPORT` when the last byte is accepted. `ST_REPORT` falls back to `ST_IDLE` after one cycle.

Top module: `chunk_sec_ecc`

## Requirements
- R1: After reset `res_vld_o` is 0, `status_o` is 0, `err_byte_o`/`err_bit_o` are 0 and `code_o` is all zeros, and the block sits in `ST_IDLE`.
- R2: With A the byte-address width (8 for 256 bytes): `code_o[2k+1]` is the XOR of every data bit of the bytes whose index has bit k set, and `code_o[2k]` is the same for bit k clear (k < A). `code_o[2A+2j+1]` is the XOR of every data bit whose position within its byte has bit j set, and `code_o[2A+2j]` is the same for bit j clear (j < 3). In check mode `code_o` carries the recomputed code.
- R3: A byte is accepted only in `ST_FILL` in a cycle with `in_vld_i` high. Idle cycles may occur between bytes. `res_vld_o` is high for exactly one cycle, the cycle after byte number `CHUNK_BYTES-1` is accepted, and is low in every other cycle.
- R4: `start_i` clears the byte counter and the parity accumulators in any state, including in the middle of a chunk. The bytes of an abandoned chunk do not affect the next result.
- R5: Bytes presented with `in_vld_i` while no chunk is open (`ST_IDLE`, `ST_REPORT`) have no effect on any result.
- R6: In check mode (`chk_mode_i`=1, sampled with `start_i`), an all-zero syndrome gives `status_o`=0 (clean).
- R7: In check mode, a syndrome in which every pair has exactly one bit set gives `status_o`=1. In that case `err_byte_o` is the odd line-pair bits and `err_bit_o` is the odd column-pair bits, which locate the flipped data bit.
- R8: In check mode, a syndrome with exactly one bit set gives `status_o`=2 (the error is in the stored code; no data bit to flip).
- R9: In check mode, every other nonzero syndrome gives `status_o`=3 (uncorrectable). `err_byte_o` and `err_bit_o` are 0 whenever `status_o` is not 1.
- R10: In encode mode (`chk_mode_i`=0 at start) `status_o` is 0 and the stored-code input is ignored.
- R11: `stored_code_i` is sampled only in the cycle the last byte is accepted. Its value during earlier bytes has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a chunk and clears the accumulators |
| chk_mode_i | input | 1 | 0 encode, 1 check; sampled with `start_i` |
| in_vld_i | input | 1 | Byte on `in_byte_i` is valid |
| in_byte_i | input | 8 | Data byte |
| stored_code_i | input | CODE_W (22) | Stored code, sampled with the last byte |
| res_vld_o | output | 1 | One-cycle result strobe |
| code_o | output | CODE_W (22) | Computed code for the last chunk |
| status_o | output | 2 | 0 clean, 1 data fix, 2 code-bit error, 3 uncorrectable |
| err_byte_o | output | ADDR_W (8) | Byte index to flip when status is 1 |
| err_bit_o | output | 3 | Bit index to flip when status is 1 |

## Verification
The assertions assume that `start_i` is a single-cycle strobe and that a chunk is never left half-filled when a result is expected. On that basis they count accepted bytes independently of the design and tie the result strobe to the full count. The stimulus keeps to this: every chunk is opened by a one-cycle start and then fed exactly `CHUNK_BYTES` bytes, with or without idle gaps. The one abandoned chunk is always followed by a fresh start. While a chunk is filling, the bench drives the inverted stored code, so any early sampling of that input shows up as a wrong outcome.

// File: rtl/chunk_ecc_pkg.sv
package chunk_ecc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_REPORT = 2'd2
    } ctrl_state_t;

    typedef enum logic [1:0] {
        RES_CLEAN    = 2'd0,
        RES_DATA_FIX = 2'd1,
        RES_CODE_HIT = 2'd2,
        RES_UNCORR   = 2'd3
    } ecc_res_t;

    localparam int COL_BITS = 3;

endpackage

// File: rtl/chunk_ecc_accum.sv
module chunk_ecc_accum #(
    parameter int ADDR_W = 8,
    parameter int CODE_W = 2 * ADDR_W + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              acc_i,
    input  logic [7:0]        byte_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [CODE_W-1:0] code_d_o
);
    import chunk_ecc_pkg::*;

    localparam int LINE_W = 2 * ADDR_W;

    logic [LINE_W-1:0] line_q, line_d;
    logic [7:0]        fold_q, fold_d;
    logic              byte_par;
    logic [2*COL_BITS-1:0] col_par;

    assign byte_par = ^byte_i;

    always_comb begin
        line_d = line_q;
        fold_d = fold_q;
        if (clr_i) begin
            line_d = '0;
            fold_d = '0;
        end else if (acc_i) begin
            fold_d = fold_q ^ byte_i;
            for (int k = 0; k < ADDR_W; k++) begin
                line_d[2*k + int'(addr_i[k])] = line_q[2*k + int'(addr_i[k])] ^ byte_par;
            end
        end
    end

    for (genvar j = 0; j < COL_BITS; j++) begin : g_col
        always_comb begin
            col_par[2*j]   = 1'b0;
            col_par[2*j+1] = 1'b0;
            for (int b = 0; b < 8; b++) begin
                if (((b >> j) & 1) != 0) col_par[2*j+1] = col_par[2*j+1] ^ fold_d[b];
                else                     col_par[2*j]   = col_par[2*j]   ^ fold_d[b];
            end
        end
    end

    assign code_d_o = {col_par, line_d};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            fold_q <= '0;
        end else begin
            line_q <= line_d;
            fold_q <= fold_d;
        end
    end

endmodule

// File: rtl/chunk_ecc_classify.sv
module chunk_ecc_classify #(
    parameter int ADDR_W = 8,
    parameter int CODE_W = 2 * ADDR_W + 6
) (
    input  logic [CODE_W-1:0]     syn_i,
    output chunk_ecc_pkg::ecc_res_t res_o,
    output logic [ADDR_W-1:0]     loc_byte_o,
    output logic [2:0]            loc_bit_o
);
    import chunk_ecc_pkg::*;

    localparam int PAIRS = ADDR_W + COL_BITS;

    logic [PAIRS-1:0] split;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign split[p] = syn_i[2*p] ^ syn_i[2*p+1];
    end

    for (genvar k = 0; k < ADDR_W; k++) begin : g_byte
        assign loc_byte_o[k] = syn_i[2*k+1];
    end

    for (genvar j = 0; j < COL_BITS; j++) begin : g_bit
        assign loc_bit_o[j] = syn_i[2*ADDR_W + 2*j + 1];
    end

    always_comb begin
        if (syn_i == '0)                  res_o = RES_CLEAN;
        else if ($countones(syn_i) == 1)  res_o = RES_CODE_HIT;
        else if (&split)                  res_o = RES_DATA_FIX;
        else                              res_o = RES_UNCORR;
    end

endmodule

// File: rtl/chunk_sec_ecc.sv
module chunk_sec_ecc #(
    parameter  int CHUNK_BYTES = 256,
    localparam int ADDR_W      = $clog2(CHUNK_BYTES),
    localparam int CODE_W      = 2 * ADDR_W + 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              chk_mode_i,
    input  logic              in_vld_i,
    input  logic [7:0]        in_byte_i,
    input  logic [CODE_W-1:0] stored_code_i,
    output logic              res_vld_o,
    output logic [CODE_W-1:0] code_o,
    output logic [1:0]        status_o,
    output logic [ADDR_W-1:0] err_byte_o,
    output logic [2:0]        err_bit_o
);
    import chunk_ecc_pkg::*;

    ctrl_state_t       state_q, state_d;
    logic [ADDR_W-1:0] cnt_q;
    logic              mode_q;
    logic              accept, last_acc, filling;
    logic [CODE_W-1:0] code_d;
    ecc_res_t          cls_res;
    logic [ADDR_W-1:0] cls_byte;
    logic [2:0]        cls_bit;

    assign accept   = filling && in_vld_i && !start_i;
    assign last_acc = accept && (cnt_q == ADDR_W'(CHUNK_BYTES - 1));

    chunk_ecc_accum #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (start_i),
        .acc_i    (accept),
        .byte_i   (in_byte_i),
        .addr_i   (cnt_q),
        .code_d_o (code_d)
    );

    chunk_ecc_classify #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_class (
        .syn_i      (code_d ^ stored_code_i),
        .res_o      (cls_res),
        .loc_byte_o (cls_byte),
        .loc_bit_o  (cls_bit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_FILL;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_FILL:   state_d = last_acc ? ST_REPORT : ST_FILL;
                ST_REPORT: state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        res_vld_o = 1'b0;
        filling   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_FILL:   filling   = 1'b1;
            ST_REPORT: res_vld_o = 1'b1;
            default:   ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            mode_q     <= 1'b0;
            code_o     <= '0;
            status_o   <= 2'd0;
            err_byte_o <= '0;
            err_bit_o  <= '0;
        end else begin
            if (start_i) begin
                cnt_q  <= '0;
                mode_q <= chk_mode_i;
            end else if (accept) begin
                cnt_q  <= cnt_q + 1'b1;
            end
            if (last_acc) begin
                code_o <= code_d;
                if (mode_q && cls_res == RES_DATA_FIX) begin
                    status_o   <= 2'(RES_DATA_FIX);
                    err_byte_o <= cls_byte;
                    err_bit_o  <= cls_bit;
                end else begin
                    status_o   <= mode_q ? 2'(cls_res) : 2'(RES_CLEAN);
                    err_byte_o <= '0;
                    err_bit_o  <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/chunk_sec_ecc_chk.sv
module chunk_sec_ecc_chk #(
    parameter int CHUNK_BYTES = 256,
    parameter int ADDR_W      = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              chk_mode_i,
    input logic              in_vld_i,
    input logic              filling,
    input logic              res_vld_o,
    input logic [1:0]        status_o,
    input logic [ADDR_W-1:0] err_byte_o,
    input logic [2:0]        err_bit_o
);
    logic [ADDR_W:0] seen_q;
    logic            mode_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q      <= '0;
            mode_seen_q <= 1'b0;
        end else if (start_i) begin
            seen_q      <= '0;
            mode_seen_q <= chk_mode_i;
        end else if (filling && in_vld_i) begin
            seen_q      <= seen_q + 1'b1;
        end
    end

    assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |=> !res_vld_o);

    assert_full_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |-> (seen_q == (ADDR_W+1)'(CHUNK_BYTES)));

    assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !res_vld_o);

    assert_encode_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld_o && !mode_seen_q) |-> (status_o == 2'd0));

    assert_loc_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != 2'd1) |-> (err_byte_o == '0 && err_bit_o == '0));

endmodule

bind chunk_sec_ecc chunk_sec_ecc_chk #(.CHUNK_BYTES(CHUNK_BYTES), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .chk_mode_i (chk_mode_i),
    .in_vld_i   (in_vld_i),
    .filling    (filling),
    .res_vld_o  (res_vld_o),
    .status_o   (status_o),
    .err_byte_o (err_byte_o),
    .err_bit_o  (err_bit_o)
);

// File: tb/chunk_sec_ecc_tb_top.sv
module chunk_sec_ecc_tb_top;
    localparam int NB   = 256;
    localparam int AW   = 8;
    localparam int CW   = 2 * AW + 6;
    localparam int NVEC = 9;

    // {kind[31:24], seed[23:16], index[15:8], bit/pos[7:0]}
    // kind 0 clean, 1 data flip, 2 code flip, 3 two data flips, 4 clean with gaps
    localparam logic [31:0] VEC [NVEC] = '{
        32'h00_01_00_00,
        32'h01_02_00_00,
        32'h01_03_FF_07,
        32'h01_04_AA_05,
        32'h02_05_00_00,
        32'h02_06_00_15,
        32'h03_07_0A_01,
        32'h03_08_7F_04,
        32'h04_09_00_00
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          chk_mode_i = 1'b0;
    logic          in_vld_i = 1'b0;
    logic [7:0]    in_byte_i = '0;
    logic [CW-1:0] stored_code_i = '0;
    logic          res_vld_o;
    logic [CW-1:0] code_o;
    logic [1:0]    status_o;
    logic [AW-1:0] err_byte_o;
    logic [2:0]    err_bit_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    logic [7:0]    mem [NB];
    logic [CW-1:0] gold;
    logic          early_vld;
    logic          got_vld, after_vld;
    logic [CW-1:0] got_code;
    logic [1:0]    got_stat;
    logic [AW-1:0] got_byte;
    logic [2:0]    got_bit;

    always #2.5 clk = ~clk;

    chunk_sec_ecc #(.CHUNK_BYTES(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chk_mode_i(chk_mode_i),
        .in_vld_i(in_vld_i), .in_byte_i(in_byte_i), .stored_code_i(stored_code_i),
        .res_vld_o(res_vld_o), .code_o(code_o), .status_o(status_o),
        .err_byte_o(err_byte_o), .err_bit_o(err_bit_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic fill_mem(input int seed);
        for (int i = 0; i < NB; i++) mem[i] = 8'(((i * 29) + (seed * 71)) ^ (i >> 3) ^ seed);
    endtask

    function automatic logic [CW-1:0] ref_code();
        logic [CW-1:0] c;
        c = '0;
        for (int i = 0; i < NB; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (mem[i][b]) begin
                    for (int k = 0; k < AW; k++) c[2*k + ((i >> k) & 1)] ^= 1'b1;
                    for (int j = 0; j < 3; j++) c[2*AW + 2*j + ((b >> j) & 1)] ^= 1'b1;
                end
            end
        end
        return c;
    endfunction

    task automatic run_chunk(input logic mode, input logic [CW-1:0] stored, input bit gaps);
        early_vld = 1'b0;
        @(negedge clk);
        start_i = 1'b1; chk_mode_i = mode;
        @(negedge clk);
        start_i = 1'b0; chk_mode_i = ~mode;
        for (int i = 0; i < NB; i++) begin
            if (res_vld_o) early_vld = 1'b1;
            if (gaps && (i % 7 == 3)) begin
                in_vld_i = 1'b0; in_byte_i = 8'hA5;
                @(negedge clk);
                if (res_vld_o) early_vld = 1'b1;
            end
            in_vld_i = 1'b1;
            in_byte_i = mem[i];
            stored_code_i = (i == NB - 1) ? stored : ~stored;
            @(negedge clk);
        end
        in_vld_i = 1'b0;
        got_vld = res_vld_o; got_code = code_o; got_stat = status_o;
        got_byte = err_byte_o; got_bit = err_bit_o;
        @(negedge clk);
        after_vld = res_vld_o;
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_bad++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int kind, idx, pos;
        repeat (3) @(negedge clk);
        check("R1 res_vld after reset", 32'(res_vld_o), 0);
        check("R1 status after reset", 32'(status_o), 0);
        check("R1 code after reset", 32'(code_o), 0);
        check("R1 err loc after reset", {err_byte_o, err_bit_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table
        for (int n = 0; n < NVEC; n++) begin
            v = VEC[n];
            kind = int'(v[31:24]); idx = int'(v[15:8]); pos = int'(v[7:0]);
            fill_mem(int'(v[23:16]));
            gold = ref_code();
            if (kind == 1) mem[idx][pos] = ~mem[idx][pos];
            if (kind == 3) begin
                mem[idx][pos] = ~mem[idx][pos];
                mem[(idx + 1) % NB][(pos + 3) % 8] = ~mem[(idx + 1) % NB][(pos + 3) % 8];
            end
            run_chunk(1'b1, (kind == 2) ? (gold ^ (CW'(1) << pos)) : gold, kind == 4);
            check("R3 no early result", 32'(early_vld), 0);
            check("R3 result strobe", 32'(got_vld), 1);
            check("R3 strobe one cycle", 32'(after_vld), 0);
            check("R2 recomputed code", 32'(got_code), 32'(ref_code()));
            case (kind)
                1: begin
                    check("R7 data fix status", 32'(got_stat), 1);
                    check("R7 byte index", 32'(got_byte), 32'(idx));
                    check("R7 bit index", 32'(got_bit), 32'(pos));
                end
                2: begin
                    check("R8 code bit status", 32'(got_stat), 2);
                    check("R9 loc zero on code hit", {got_byte, got_bit}, 0);
                end
                3: begin
                    check("R9 uncorrectable", 32'(got_stat), 3);
                    check("R9 loc zero", {got_byte, got_bit}, 0);
                end
                default: begin
                    check("R6 clean status (R11 stored sampled late)", 32'(got_stat), 0);
                end
            endcase
        end

        // encode mode, stored code garbage
        fill_mem(33);
        gold = ref_code();
        run_chunk(1'b0, ~gold, 1'b0);
        check("R2 encode code", 32'(got_code), 32'(gold));
        check("R10 encode status", 32'(got_stat), 0);

        // abandoned chunk then restart
        fill_mem(44);
        gold = ref_code();
        @(negedge clk); start_i = 1'b1; chk_mode_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        early_vld = 1'b0;
        for (int i = 0; i < 100; i++) begin
            in_vld_i = 1'b1; in_byte_i = 8'(i * 13 + 1);
            @(negedge clk);
            if (res_vld_o) early_vld = 1'b1;
        end
        in_vld_i = 1'b0;
        check("R4 no result from abandoned chunk", 32'(early_vld), 0);
        run_chunk(1'b1, gold, 1'b0);
        check("R4 restart code", 32'(got_code), 32'(gold));
        check("R4 restart status", 32'(got_stat), 0);

        // bytes while idle
        early_vld = 1'b0;
        for (int i = 0; i < 50; i++) begin
            in_vld_i = 1'b1; in_byte_i = 8'(i * 7 + 3);
            @(negedge clk);
            if (res_vld_o) early_vld = 1'b1;
        end
        in_vld_i = 1'b0;
        check("R5 idle bytes give no result", 32'(early_vld), 0);
        check("R5 outputs held", 32'(code_o), 32'(gold));
        fill_mem(55);
        gold = ref_code();
        run_chunk(1'b0, '0, 1'b1);
        check("R5 code after idle bytes", 32'(got_code), 32'(gold));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule